// File: doc/BRIEF.md
# GPIO Interrupt Cause Aggregator

This block sits behind the input-conditioning stage of a 32-line general-purpose I/O port and turns that port's data-in vector into interrupt requests. The data-in vector arrives already synchronised and already corrected for polarity. The block senses each line in two ways. A line can raise a request directly while it is high, which is level sensing. It can also have its 0-to-1 transitions captured in a sticky edge-cause register, which is edge sensing.

Each line has its own enable bit for each of the two paths. The two paths are merged per line into one pending bit. The pending bits are then reduced in blocks of eight consecutive lines, which gives one registered request output per block. For 32 lines there are four request outputs.

Software reaches the edge-cause register and the two enable registers over a simple single-cycle register bus. Captured edges are acknowledged by writing zeros into the edge-cause register. The two enable registers sit at a fixed base plus a parameterised bank offset. This lets the same block serve more than one interrupt target.

Top module: `gpio_irq_aggr`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the edge-cause register, the edge-enable register and the level-enable register all read zero, and every request output is low.
- R2: The edge-cause register is at byte address 0x14. The edge-enable register is at 0x18 plus `MASK_OFS`, and the level-enable register is at 0x1C plus `MASK_OFS`. Both enable registers hold what is written to them. Any other address reads zero.
- R3: An edge-cause bit is set at a clock edge when its data-in bit is 1 and was 0 on the previous cycle. A 1-to-0 transition sets nothing. A line that is already high when reset is released does not count as a transition.
- R4: A set edge-cause bit stays set, whatever data-in does afterwards, until software clears it.
- R5: A write to the edge-cause address clears every bit whose write-data bit is 0. Bits whose write-data bit is 1 are left as they are.
- R6: If a new rising transition arrives in the same cycle as a write that clears the same bit, the bit ends up set.
- R7: Line i is level-pending while data-in bit i and level-enable bit i are both 1.
- R8: Line i is pending when it is level-pending, or when edge-cause bit i and edge-enable bit i are both 1.
- R9: Request output g is the OR of the pending bits of lines 8g through 8g+7. Bit 0 of the output therefore covers lines 0 to 7, and bit 3 covers lines 24 to 31.
- R10: Each request output is registered. It follows the pending condition exactly one clock cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| din_i | input | 32 | Polarity-corrected, synchronised data-in vector |
| bus_wr_i | input | 1 | Register write strobe, one cycle per write |
| bus_addr_i | input | 8 | Register byte address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data, combinational from the address |
| grp_irq_o | output | 4 | One registered request per block of eight lines |

## Verification
The level path is driven with a vector table. The table puts single lines in different blocks, pairs of lines in separate blocks, and data patterns that are entirely masked or complementary to the enable pattern. Together these show the per-line AND and the grouping boundaries, and they show that a masked line gives no request.

The edge path is tried with a rise followed by a fall, with a steady high line across reset release, and with a fall on its own. This tells a latched edge apart from a level and from a falling edge.

Acknowledge writes are tried with all ones, with a single zero, and with a zero that lands in the same cycle as a new rise. These patterns separate write-zero-to-clear from write-one-to-clear, and show which side wins a collision.

Two things are checked at the cycle boundaries: the output lag of one cycle, and a level line and an edge line in different blocks active at the same time.

// File: rtl/gpio_irq_pkg.sv
// Package: shared address constants and register select encoding for the
// GPIO interrupt cause aggregator. Assumes byte addressing of 32-bit words.
package gpio_irq_pkg;

    localparam logic [7:0] CAUSE_ADDR     = 8'h14;
    localparam logic [7:0] EDGE_EN_BASE   = 8'h18;
    localparam logic [7:0] LEVEL_EN_BASE  = 8'h1C;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_CAUSE = 2'd1,
        SEL_EDGE  = 2'd2,
        SEL_LEVEL = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/gpio_edge_latch.sv
// Module: gpio_edge_latch
// Detects 0-to-1 transitions on each data-in bit and holds them in a sticky
// cause register. Software clears bits by writing 0; a 1 leaves a bit alone.
// A new rise in the same cycle as a clearing write wins.
// Assumes din is already synchronous to clk. The first cycle after reset only
// samples din, so a line that is high at reset release records no edge.
module gpio_edge_latch #(
    parameter int PINS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] din,
    input  logic            ack_wr,
    input  logic [PINS-1:0] ack_data,
    output logic [PINS-1:0] cause
);

    logic [PINS-1:0] din_prev;
    logic            armed;
    logic [PINS-1:0] rise;
    logic [PINS-1:0] cause_nxt;

    // Keep the previous data-in value and note when it becomes valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            din_prev <= '0;
            armed    <= 1'b0;
        end else begin
            din_prev <= din;
            armed    <= 1'b1;
        end
    end

    // Rising transitions, suppressed until the previous sample is valid.
    always_comb begin
        rise = armed ? (din & ~din_prev) : '0;
    end

    // Acknowledge by writing zeros, then let new rises set bits again.
    always_comb begin
        cause_nxt = ack_wr ? (cause & ack_data) : cause;
        cause_nxt = cause_nxt | rise;
    end

    // Cause register.
    always_ff @(posedge clk) begin
        if (!rst_n) cause <= '0;
        else        cause <= cause_nxt;
    end

    // R4
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_wr |=> ((cause & $past(cause)) == $past(cause)));

    // R5
    write_one_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_wr |=> ((cause & $past(ack_data & cause)) == $past(ack_data & cause)));

    // R5
    write_zero_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_wr |=> ((cause & ~$past(ack_data) & ~$past(rise)) == '0));

    // R6
    rise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((cause & $past(rise)) == $past(rise)));

    // R3
    no_fall_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_wr |=> ((cause & ~$past(cause) & ~$past(din)) == '0));

endmodule

// File: rtl/gpio_mask_regs.sv
// Module: gpio_mask_regs
// Holds the per-line edge-enable and level-enable registers.
// Assumes the write strobes come from an address decode with at most one
// strobe active per cycle.
module gpio_mask_regs #(
    parameter int PINS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            edge_wr,
    input  logic            level_wr,
    input  logic [PINS-1:0] wdata,
    output logic [PINS-1:0] edge_en,
    output logic [PINS-1:0] level_en
);

    // Edge-enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)       edge_en <= '0;
        else if (edge_wr) edge_en <= wdata;
    end

    // Level-enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)        level_en <= '0;
        else if (level_wr) level_en <= wdata;
    end

    // R1
    en_reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> (edge_en == '0 && level_en == '0));

endmodule

// File: rtl/gpio_irq_group.sv
// Module: gpio_irq_group
// Merges the level and edge paths into one pending bit per line, then ORs
// the lines in blocks of GRP and registers one request per block.
// Assumes PINS is a multiple of GRP.
module gpio_irq_group #(
    parameter int PINS = 32,
    parameter int GRP  = 8,
    localparam int NGRP = PINS / GRP
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] din,
    input  logic [PINS-1:0] level_en,
    input  logic [PINS-1:0] cause,
    input  logic [PINS-1:0] edge_en,
    output logic [NGRP-1:0] grp_irq
);

    logic [PINS-1:0] pend;
    logic [NGRP-1:0] grp_any;

    // Per-line pending: level path OR enabled edge path.
    always_comb begin
        pend = (din & level_en) | (cause & edge_en);
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        // OR of this block's pending lines.
        assign grp_any[g] = |pend[g*GRP +: GRP];

        // R9
        grp_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (|(din[g*GRP +: GRP] & level_en[g*GRP +: GRP])) |=> grp_irq[g]);

        // R10
        grp_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            grp_irq[g] |-> $past(|(cause[g*GRP +: GRP] & edge_en[g*GRP +: GRP])
                               || |(din[g*GRP +: GRP] & level_en[g*GRP +: GRP])));
    end

    // Registered request outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) grp_irq <= '0;
        else        grp_irq <= grp_any;
    end

endmodule

// File: rtl/gpio_irq_aggr.sv
// Module: gpio_irq_aggr (top)
// Register decode, read mux and wiring of edge latch, enable registers and
// group reduction. Assumes single-cycle writes and a combinational read.
module gpio_irq_aggr #(
    parameter int PINS     = 32,
    parameter int GRP      = 8,
    parameter int ADDR_W   = 8,
    parameter int MASK_OFS = 0,
    localparam int NGRP    = PINS / GRP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PINS-1:0]   din_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [PINS-1:0]   bus_wdata_i,
    output logic [PINS-1:0]   bus_rdata_o,
    output logic [NGRP-1:0]   grp_irq_o
);
    import gpio_irq_pkg::*;

    localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(CAUSE_ADDR);
    localparam logic [ADDR_W-1:0] A_EDGE  = ADDR_W'(int'(EDGE_EN_BASE) + MASK_OFS);
    localparam logic [ADDR_W-1:0] A_LEVEL = ADDR_W'(int'(LEVEL_EN_BASE) + MASK_OFS);

    reg_sel_e        sel;
    logic [PINS-1:0] cause;
    logic [PINS-1:0] edge_en;
    logic [PINS-1:0] level_en;

    // Address decode.
    always_comb begin
        if      (bus_addr_i == A_CAUSE) sel = SEL_CAUSE;
        else if (bus_addr_i == A_EDGE)  sel = SEL_EDGE;
        else if (bus_addr_i == A_LEVEL) sel = SEL_LEVEL;
        else                            sel = SEL_NONE;
    end

    // Read mux.
    always_comb begin
        case (sel)
            SEL_CAUSE: bus_rdata_o = cause;
            SEL_EDGE:  bus_rdata_o = edge_en;
            SEL_LEVEL: bus_rdata_o = level_en;
            default:   bus_rdata_o = '0;
        endcase
    end

    gpio_edge_latch #(.PINS(PINS)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (din_i),
        .ack_wr   (bus_wr_i && sel == SEL_CAUSE),
        .ack_data (bus_wdata_i),
        .cause    (cause)
    );

    gpio_mask_regs #(.PINS(PINS)) u_en (
        .clk      (clk),
        .rst_n    (rst_n),
        .edge_wr  (bus_wr_i && sel == SEL_EDGE),
        .level_wr (bus_wr_i && sel == SEL_LEVEL),
        .wdata    (bus_wdata_i),
        .edge_en  (edge_en),
        .level_en (level_en)
    );

    gpio_irq_group #(.PINS(PINS), .GRP(GRP)) u_grp (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (din_i),
        .level_en (level_en),
        .cause    (cause),
        .edge_en  (edge_en),
        .grp_irq  (grp_irq_o)
    );

    // R1
    out_reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> (grp_irq_o == '0 && cause == '0));

endmodule

// File: tb/test_gpio_irq_aggr.sv
module test_gpio_irq_aggr;
    localparam int OFS = 'h20;
    localparam logic [7:0] A_CAUSE = 8'h14;
    localparam logic [7:0] A_EDGE  = 8'h18 + OFS;
    localparam logic [7:0] A_LEVEL = 8'h1C + OFS;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] din;
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [3:0]  grp;
    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    gpio_irq_aggr #(.MASK_OFS(OFS)) i_gpio_irq_aggr (
        .clk(clk), .rst_n(rst_n), .din_i(din), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .grp_irq_o(grp)
    );

    // Level-path table: data-in, level enable, expected request outputs.
    localparam logic [31:0] T_DIN [7] = '{32'h0000_0100, 32'h8000_0000, 32'h0001_0001,
                                          32'hFFFF_00FF, 32'h0F0F_0F0F, 32'h0100_0080,
                                          32'h0000_0000};
    localparam logic [31:0] T_LEN [7] = '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
                                          32'h0000_FF00, 32'hF0F0_F0F0, 32'h0100_0000,
                                          32'hFFFF_FFFF};
    localparam logic [3:0]  T_EXP [7] = '{4'b0010, 4'b1000, 4'b0101,
                                          4'b0000, 4'b0000, 4'b1000, 4'b0000};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        chk(req, rdata, exp);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; din = 32'h0000_00FF; wr = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1 chk("R1 grp after reset", {28'd0, grp}, 32'd0);
        rd_chk("R1 edge enable", A_EDGE, 32'd0);
        rd_chk("R1 level enable", A_LEVEL, 32'd0);
        repeat (2) @(negedge clk);
        rd_chk("R3 no edge at reset release", A_CAUSE, 32'd0);
        din = 32'd0;

        // R2 address map
        wr_reg(A_EDGE, 32'hA5A5_A5A5);
        wr_reg(A_LEVEL, 32'h1234_5678);
        rd_chk("R2 edge enable", A_EDGE, 32'hA5A5_A5A5);
        rd_chk("R2 level enable", A_LEVEL, 32'h1234_5678);
        rd_chk("R2 unmapped base", 8'h18, 32'd0);
        rd_chk("R2 unmapped data", 8'h10, 32'd0);
        wr_reg(A_EDGE, 32'd0);

        // R7 / R9 / R10 level table
        for (int i = 0; i < 7; i++) begin
            wr_reg(A_LEVEL, T_LEN[i]);
            din = T_DIN[i];
            @(negedge clk);
            #1 chk("R7 R9 level table", {28'd0, grp}, {28'd0, T_EXP[i]});
        end
        wr_reg(A_LEVEL, 32'd0);
        wr_reg(A_CAUSE, 32'd0);
        @(negedge clk);

        // R3 / R10 / R4 edge path on line 9
        wr_reg(A_EDGE, 32'h0000_0200);
        din = 32'h0000_0200;
        #1 chk("R10 no request before edge", {28'd0, grp}, 32'd0);
        @(negedge clk);
        #1 chk("R10 output lags cause", {28'd0, grp}, 32'd0);
        rd_chk("R3 rise latched", A_CAUSE, 32'h0000_0200);
        @(negedge clk);
        #1 chk("R9 edge request block1", {28'd0, grp}, 32'h2);
        din = 32'd0;
        repeat (2) @(negedge clk);
        #1 chk("R4 request held", {28'd0, grp}, 32'h2);
        rd_chk("R4 cause held", A_CAUSE, 32'h0000_0200);

        // R8 level and edge together
        wr_reg(A_LEVEL, 32'h1000_0000);
        din = 32'h1000_0000;
        @(negedge clk);
        #1 chk("R8 level plus edge", {28'd0, grp}, 32'hA);
        wr_reg(A_EDGE, 32'd0);
        @(negedge clk);
        #1 chk("R8 edge disabled", {28'd0, grp}, 32'h8);

        // R5 acknowledge
        wr_reg(A_CAUSE, 32'hFFFF_FFFF);
        rd_chk("R5 write ones keep", A_CAUSE, 32'h1000_0200);
        wr_reg(A_CAUSE, 32'hFFFF_FDFF);
        rd_chk("R5 write zero clears", A_CAUSE, 32'h1000_0000);
        wr_reg(A_CAUSE, 32'd0);
        rd_chk("R5 clear all", A_CAUSE, 32'd0);
        wr_reg(A_LEVEL, 32'd0);

        // R3 falling edge ignored
        din = 32'd0;
        repeat (2) @(negedge clk);
        rd_chk("R3 fall ignored", A_CAUSE, 32'd0);

        // R6 collision
        din = 32'h0000_0010;
        repeat (2) @(negedge clk);
        rd_chk("R6 setup", A_CAUSE, 32'h0000_0010);
        wr = 1'b1; addr = A_CAUSE; wdata = 32'd0; din = 32'h0000_0011;
        @(negedge clk);
        wr = 1'b0;
        rd_chk("R6 set wins", A_CAUSE, 32'h0000_0001);

        // R1 reset clears everything
        wr_reg(A_EDGE, 32'hFFFF_FFFF);
        wr_reg(A_LEVEL, 32'hFFFF_FFFF);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1 chk("R1 grp reset", {28'd0, grp}, 32'd0);
        rd_chk("R1 cause reset", A_CAUSE, 32'd0);
        rd_chk("R1 edge reset", A_EDGE, 32'd0);
        rd_chk("R1 level reset", A_LEVEL, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule